// File: doc/BRIEF.md
# Multiword Variable Left Shifter

This block shifts a wide accumulator left by a variable number of places. The accumulator is held as a row of short words. The shift count is never turned into a binary number. Instead, the low field of an instruction word is loaded into a small right-shifting count register, and that register serves as the loop counter. The block shifts the accumulator by one place for each zero bit it reads below the lowest set bit of the field, and by one more place for the set bit itself.

Each one-place pass doubles every short word by adding it to itself. The words are handled in order from least to most significant, one word per clock. The carry out of each word feeds the next word. The step for the most significant word also shifts the count register right and decides whether to loop back. That decision uses bit 0 of the count register as it stood before that shift. If the bit was 0, another pass follows. If it was 1, the operation ends.

A caller pulses `start_i` with the instruction and the initial accumulator. It then waits for the one-cycle `done_o` pulse and reads `result_o`. The result stays there until the next accepted start.

Top module: `mwls_top`

## Requirements
- R1: After reset, and while reset is held, `done_o` is 0 and `result_o` is all zeros.
- R2: Let k be the index of the lowest set bit in the shift field `instr_i[SHF_W-1:0]`. The shift amount is P = k+1 places. The final `result_o` equals the initial accumulator shifted left by P places and truncated to ACC_W bits (the field value 0x01 gives 1 place, 0x08 gives 4 places, 0x80 gives 8 places).
- R3: Each pass doubles the short words in order from least to most significant. The carry into word 0 is zero, and the top bit of each word moves into bit 0 of the next word. Bits therefore cross short-word boundaries unchanged.
- R4: For a shift of P places, `done_o` rises exactly 4*P rising clock edges after the edge that accepted `start_i` (N_WORDS = 4). It stays high for exactly one cycle.
- R5: A shift field of all zeros gives a zero-place shift. In that case `done_o` is high right after the accepting edge, `result_o` equals the loaded accumulator, and no pass runs.
- R6: Instruction bits at and above position SHF_W have no effect on the shift amount or on the result.
- R7: A `start_i` pulse that arrives while an operation is in progress is ignored. The running operation finishes with its own result and timing, and no extra `done_o` pulse follows.
- R8: Bits shifted out of the top of the most significant word are discarded.
- R9: The count register shifts right only during the most-significant-word step. The loop-back decision uses bit 0 of that register before the shift. The loop returns to word 0 when that bit is 0.
- R10: While the block is idle and no start is accepted, `result_o` holds its value.
- R11: During a pass, only the short word selected for the current step changes on that clock.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| start_i | input | 1 | Start request, sampled on the clock edge |
| instr_i | input | INSTR_W | Instruction word; the low SHF_W bits form the shift field |
| acc_i | input | SW_W*N_WORDS | Initial accumulator value |
| result_o | output | SW_W*N_WORDS | Registered accumulator; holds the final result after done |
| done_o | output | 1 | One-cycle completion pulse |

## Verification
The embedded assertions check the step mechanics on every cycle:
- The word index advances by one on each step and returns to word 0 after a most-significant step whose tested bit is 0.
- The count register shifts right only on that step and holds at all other times.
- The count register never becomes empty while a pass is running, so the loop cannot run forever.
- Short words other than the selected one stay unchanged.
- The done pulse never overlaps a running operation.

Only the bench scenarios can show end-to-end results: the final value for each shift field, carries across word boundaries, loss of the top bits, the exact done latency, the ignored upper instruction bits, and the rejection of a start that arrives mid-operation.

// File: rtl/mwls_pkg.sv
package mwls_pkg;

  typedef enum logic [0:0] {
    PH_IDLE = 1'b0,
    PH_RUN  = 1'b1
  } mwls_phase_e;

endpackage

// File: rtl/mwls_word_double.sv
module mwls_word_double #(
  parameter int W = 16
) (
  input  logic [W-1:0] word_i,
  input  logic         carry_i,
  output logic [W-1:0] word_o,
  output logic         carry_o
);

  logic [W:0] sum;

  always_comb begin
    sum     = {1'b0, word_i} + {1'b0, word_i} + {{W{1'b0}}, carry_i};
    word_o  = sum[W-1:0];
    carry_o = sum[W];
  end

endmodule

// File: rtl/mwls_count_sreg.sv
module mwls_count_sreg #(
  parameter int SHF_W = 8
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             load_i,
  input  logic [SHF_W-1:0] field_i,
  input  logic             shift_i,
  input  logic             active_i,
  output logic             lsb_o
);

  logic [SHF_W-1:0] s_q;

  always_ff @(posedge clk) begin
    if (rst) begin
      s_q <= '0;
    end else if (load_i) begin
      s_q <= field_i;
    end else if (shift_i) begin
      s_q <= {1'b0, s_q[SHF_W-1:1]};
    end
  end

  assign lsb_o = s_q[0];

  // R9
  cnt_shift_chk: assert property (@(posedge clk) disable iff (rst)
    (shift_i && !load_i) |=> (s_q == ($past(s_q) >> 1)));

  // R9
  cnt_hold_chk: assert property (@(posedge clk) disable iff (rst)
    (!shift_i && !load_i) |=> $stable(s_q));

  // R5
  cnt_nonempty_chk: assert property (@(posedge clk) disable iff (rst)
    active_i |-> (s_q != '0));

endmodule

// File: rtl/mwls_seq.sv
module mwls_seq
  import mwls_pkg::*;
#(
  parameter int N_WORDS = 4
) (
  input  logic                         clk,
  input  logic                         rst,
  input  logic                         start_i,
  input  logic                         zero_i,
  input  logic                         lsb_i,
  output logic                         load_o,
  output logic                         step_o,
  output logic [$clog2(N_WORDS)-1:0]   idx_o,
  output logic                         last_o,
  output logic                         finish_o
);

  localparam int IDX_W = $clog2(N_WORDS);
  localparam logic [IDX_W-1:0] LAST_IDX = IDX_W'(N_WORDS - 1);

  mwls_phase_e      ph_q;
  logic [IDX_W-1:0] idx_q;

  assign load_o   = start_i && (ph_q == PH_IDLE);
  assign step_o   = (ph_q == PH_RUN);
  assign last_o   = step_o && (idx_q == LAST_IDX);
  assign finish_o = last_o && lsb_i;
  assign idx_o    = idx_q;

  always_ff @(posedge clk) begin
    if (rst) begin
      ph_q  <= PH_IDLE;
      idx_q <= '0;
    end else if (load_o) begin
      idx_q <= '0;
      ph_q  <= zero_i ? PH_IDLE : PH_RUN;
    end else if (step_o) begin
      if (idx_q == LAST_IDX) begin
        idx_q <= '0;
        if (lsb_i) begin
          ph_q <= PH_IDLE;
        end
      end else begin
        idx_q <= idx_q + IDX_W'(1);
      end
    end
  end

  // R3
  idx_advance_chk: assert property (@(posedge clk) disable iff (rst)
    (step_o && idx_q != LAST_IDX) |=> (step_o && idx_q == $past(idx_q) + IDX_W'(1)));

  // R9
  loop_back_chk: assert property (@(posedge clk) disable iff (rst)
    (last_o && !lsb_i) |=> (step_o && idx_q == '0));

  // R4
  stop_chk: assert property (@(posedge clk) disable iff (rst)
    finish_o |=> !step_o);

endmodule

// File: rtl/mwls_top.sv
module mwls_top #(
  parameter int SW_W    = 16,
  parameter int N_WORDS = 4,
  parameter int INSTR_W = 16,
  parameter int SHF_W   = 8
) (
  input  logic                      clk,
  input  logic                      rst,
  input  logic                      start_i,
  input  logic [INSTR_W-1:0]        instr_i,
  input  logic [SW_W*N_WORDS-1:0]   acc_i,
  output logic [SW_W*N_WORDS-1:0]   result_o,
  output logic                      done_o
);

  localparam int IDX_W = $clog2(N_WORDS);

  logic [SHF_W-1:0] field;
  logic             unused_hi;
  logic             zero_field;
  logic             load, step, last, finish, lsb;
  logic [IDX_W-1:0] idx;
  logic [SW_W-1:0]  acc_q [N_WORDS];
  logic [SW_W-1:0]  cur_word, dbl_word;
  logic             cin, dbl_carry, carry_q;
  logic             done_q;

  assign field      = instr_i[SHF_W-1:0];
  assign unused_hi  = ^instr_i[INSTR_W-1:SHF_W];
  assign zero_field = (field == '0);

  mwls_seq #(.N_WORDS(N_WORDS)) u_seq (
    .clk      (clk),
    .rst      (rst),
    .start_i  (start_i),
    .zero_i   (zero_field),
    .lsb_i    (lsb),
    .load_o   (load),
    .step_o   (step),
    .idx_o    (idx),
    .last_o   (last),
    .finish_o (finish)
  );

  mwls_count_sreg #(.SHF_W(SHF_W)) u_cnt (
    .clk      (clk),
    .rst      (rst),
    .load_i   (load),
    .field_i  (field),
    .shift_i  (last),
    .active_i (step),
    .lsb_o    (lsb)
  );

  assign cur_word = acc_q[idx];
  assign cin      = (idx == '0) ? 1'b0 : carry_q;

  mwls_word_double #(.W(SW_W)) u_dbl (
    .word_i  (cur_word),
    .carry_i (cin),
    .word_o  (dbl_word),
    .carry_o (dbl_carry)
  );

  always_ff @(posedge clk) begin
    if (rst) begin
      carry_q <= 1'b0;
      done_q  <= 1'b0;
    end else begin
      carry_q <= step ? dbl_carry : 1'b0;
      done_q  <= (load && zero_field) || finish;
    end
  end

  for (genvar k = 0; k < N_WORDS; k++) begin : g_word
    always_ff @(posedge clk) begin
      if (rst) begin
        acc_q[k] <= '0;
      end else if (load) begin
        acc_q[k] <= acc_i[k*SW_W +: SW_W];
      end else if (step && idx == IDX_W'(k)) begin
        acc_q[k] <= dbl_word;
      end
    end

    assign result_o[k*SW_W +: SW_W] = acc_q[k];

    // R11
    word_isolate_chk: assert property (@(posedge clk) disable iff (rst)
      (step && idx != IDX_W'(k)) |=> $stable(acc_q[k]));

    // R10
    word_idle_hold_chk: assert property (@(posedge clk) disable iff (rst)
      (!step && !load) |=> $stable(acc_q[k]));
  end

  assign done_o = done_q;

  // R4
  done_idle_chk: assert property (@(posedge clk) disable iff (rst)
    done_q |-> !step);

  // R3
  carry_base_chk: assert property (@(posedge clk) disable iff (rst)
    (step && idx == '0) |-> !cin);

endmodule

// File: tb/mwls_top_tb.sv
module mwls_top_tb;

  localparam int SW_W    = 16;
  localparam int N_WORDS = 4;
  localparam int INSTR_W = 16;
  localparam int SHF_W   = 8;
  localparam int ACC_W   = SW_W * N_WORDS;
  localparam int NV      = 8;

  localparam logic [INSTR_W-1:0] T_INSTR [NV] = '{
    16'h0001, 16'h0008, 16'h0080, 16'h0006,
    16'hFF10, 16'h0100, 16'h0002, 16'h0040
  };
  localparam logic [ACC_W-1:0] T_ACC [NV] = '{
    64'h0000_0000_0000_0001, 64'h0000_0000_0000_FFFF,
    64'h8000_0000_0000_0001, 64'h1234_5678_9ABC_DEF0,
    64'h0000_0000_0000_0003, 64'hDEAD_BEEF_0000_1111,
    64'hFFFF_FFFF_FFFF_FFFF, 64'h0001_0000_0000_8000
  };
  localparam logic [ACC_W-1:0] T_EXP [NV] = '{
    64'h0000_0000_0000_0002, 64'h0000_0000_000F_FFF0,
    64'h0000_0000_0000_0100, 64'h48D1_59E2_6AF3_7BC0,
    64'h0000_0000_0000_0060, 64'hDEAD_BEEF_0000_1111,
    64'hFFFF_FFFF_FFFF_FFFC, 64'h0080_0000_0040_0000
  };
  localparam int T_PLACES [NV] = '{1, 4, 8, 2, 5, 0, 2, 7};

  logic               clk = 1'b0;
  logic               rst = 1'b1;
  logic               start_i = 1'b0;
  logic [INSTR_W-1:0] instr_i = '0;
  logic [ACC_W-1:0]   acc_i = '0;
  logic [ACC_W-1:0]   result_o;
  logic               done_o;

  int n_checks = 0;
  int n_fail   = 0;

  always #2.5 clk = ~clk;

  mwls_top #(
    .SW_W(SW_W), .N_WORDS(N_WORDS), .INSTR_W(INSTR_W), .SHF_W(SHF_W)
  ) u_dut (
    .clk      (clk),
    .rst      (rst),
    .start_i  (start_i),
    .instr_i  (instr_i),
    .acc_i    (acc_i),
    .result_o (result_o),
    .done_o   (done_o)
  );

  task automatic check(input logic ok, input string req,
                       input logic [ACC_W-1:0] act, input logic [ACC_W-1:0] exp);
    n_checks++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic finish_run();
    $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
    $finish;
  endtask

  // launch: drive start for one edge, return edges until done
  task automatic run_op(input logic [INSTR_W-1:0] ins, input logic [ACC_W-1:0] a,
                        output int edges);
    @(negedge clk);
    start_i = 1'b1;
    instr_i = ins;
    acc_i   = a;
    @(posedge clk);
    @(negedge clk);
    start_i = 1'b0;
    instr_i = '0;
    acc_i   = '0;
    edges   = 0;
    while (!done_o && edges < 200) begin
      @(posedge clk);
      @(negedge clk);
      edges++;
    end
  endtask

  initial begin : watchdog
    repeat (100000) @(posedge clk);
    n_checks++;
    n_fail++;
    $display("FAIL watchdog actual=%h expected=%h", 1, 0);
    finish_run();
  end

  initial begin : main
    int edges;
    repeat (3) @(posedge clk);
    @(negedge clk);
    // R1: state during reset
    check(done_o == 1'b0, "R1 done in reset", {63'd0, done_o}, '0);
    check(result_o == '0, "R1 result in reset", result_o, '0);
    rst = 1'b0;
    @(negedge clk);
    check(done_o == 1'b0 && result_o == '0, "R1 after reset", result_o, '0);

    // R2 R3 R4 R5 R6 R8: table walk
    for (int i = 0; i < NV; i++) begin
      run_op(T_INSTR[i], T_ACC[i], edges);
      check(result_o == T_EXP[i], $sformatf("R2 R3 R8 result vec %0d", i),
            result_o, T_EXP[i]);
      check(edges == 4 * T_PLACES[i], $sformatf("R4 R5 latency vec %0d", i),
            ACC_W'(edges), ACC_W'(4 * T_PLACES[i]));
      @(posedge clk);
      @(negedge clk);
      check(done_o == 1'b0, $sformatf("R4 pulse width vec %0d", i),
            {63'd0, done_o}, '0);
    end

    // R6: same field, different upper bits, same result
    run_op(16'hA504, 64'h0000_0000_0000_0001, edges);
    check(result_o == 64'h8 && edges == 12, "R6 upper bits ignored",
          result_o, 64'h8);

    // R7 R10: start while busy is ignored; result holds afterwards
    @(negedge clk);
    start_i = 1'b1;
    instr_i = 16'h0008;
    acc_i   = 64'h1;
    @(posedge clk);
    @(negedge clk);
    start_i = 1'b0;
    edges   = 0;
    repeat (3) begin
      @(posedge clk);
      @(negedge clk);
      edges++;
    end
    start_i = 1'b1;
    instr_i = 16'h0001;
    acc_i   = '1;
    @(posedge clk);
    @(negedge clk);
    edges++;
    start_i = 1'b0;
    while (!done_o && edges < 200) begin
      @(posedge clk);
      @(negedge clk);
      edges++;
    end
    check(edges == 16, "R7 latency unaffected", ACC_W'(edges), 64'd16);
    check(result_o == 64'h10, "R7 result unaffected", result_o, 64'h10);
    begin
      int extra = 0;
      repeat (20) begin
        @(posedge clk);
        @(negedge clk);
        if (done_o) extra++;
      end
      check(extra == 0, "R7 no extra done", ACC_W'(extra), '0);
    end
    check(result_o == 64'h10, "R10 result holds idle", result_o, 64'h10);

    // R1: reset in the middle of an operation
    @(negedge clk);
    start_i = 1'b1;
    instr_i = 16'h0080;
    acc_i   = 64'h5;
    @(posedge clk);
    @(negedge clk);
    start_i = 1'b0;
    repeat (5) @(posedge clk);
    @(negedge clk);
    rst = 1'b1;
    @(posedge clk);
    @(negedge clk);
    check(done_o == 1'b0 && result_o == '0, "R1 mid-op reset", result_o, '0);
    rst = 1'b0;
    begin
      int seen = 0;
      repeat (40) begin
        @(posedge clk);
        @(negedge clk);
        if (done_o) seen++;
      end
      check(seen == 0, "R1 no done after reset", ACC_W'(seen), '0);
    end

    // R9: two back-to-back ops reload the count register
    run_op(16'h0004, 64'h1, edges);
    run_op(16'h0001, 64'h3, edges);
    check(result_o == 64'h6 && edges == 4, "R9 count reload", result_o, 64'h6);

    finish_run();
  end

endmodule